// File: doc/BRIEF.md
# Keyboard Interrupt Flag Controller

This block watches a group of key input lines and latches one sticky flag per line when that line shows activity. Each line has three settings: an enable bit, a polarity bit and a mode bit. The polarity bit sets the active level. The mode bit selects between a level-sensitive flag and a flag that sets only on a transition into the active level. The edge choice lets the same unit act as a general edge-triggered interrupt source. The inputs pass through a synchronizer before detection, so the lines may be driven from outside the clock domain.

The flag register is visible at all times, and observing it changes nothing. Software clears flags one bit at a time by writing the flag register: a zero clears that bit and a one leaves it unchanged. The interrupt request is a registered OR of the enabled flags. Every write to the flag register drops the request for one cycle. If enabled flags are still set after a clear, the request therefore shows a fresh rising edge for each of them.

A small write port, made of a strobe, a 2-bit select and a data word, loads the enable, polarity and mode registers and performs flag clears.

Top module: `kbi_ctrl`

## Requirements
- R1: After reset the flags, the interrupt request and the enable register are all zero. Polarity is all zero, which makes every line active-low. Mode is all zero, which selects level detection.
- R2: Each line passes through a synchronizer of SYNC_STAGES flops (default 2). A change on a line drives its flag on the third rising clock edge after the change, and not before.
- R3: In level mode (mode bit 0) a flag sets on every cycle in which its synchronized line equals its polarity bit. A polarity bit of 1 means active-high and 0 means active-low. If the line is held at the active level, the flag sets again after it is cleared.
- R4: In edge mode (mode bit 1) a flag sets only when the synchronized line moves from the inactive level to the active level. Holding the line at the active level does not set the flag again after a clear, and a move away from the active level sets nothing.
- R5: Flags are sticky. A set flag stays set after its line goes back to the inactive level. The flag output can be read without a read strobe, and reading it clears nothing.
- R6: A write with select 0 clears each flag bit whose data bit is 0 and leaves each flag bit whose data bit is 1 unchanged.
- R7: When a detection and a clear hit the same flag bit in the same cycle, the flag ends up set.
- R8: The interrupt request is a register. It reflects the OR of (flags AND enable) one clock after the flags or the enable change.
- R9: Any write with select 0 forces the interrupt request low for the cycle that follows. The request returns on the next cycle if enabled flags remain set, so each remaining flag produces its own rising edge.
- R10: A line whose enable bit is 0 still latches its flag but does not raise the interrupt request.
- R11: The write select codes are 0 for flag clear, 1 for enable, 2 for polarity and 3 for mode. A write with select 1, 2 or 3 does not change any flag by itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| key_pin | input | N_LINES | Asynchronous key input lines |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select (0 flags, 1 enable, 2 polarity, 3 mode) |
| wr_data | input | N_LINES | Write data |
| key_flags | output | N_LINES | Sticky flag register |
| key_irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with N_LINES = 8 and SYNC_STAGES = 2. With these values every line can take its own combination of mode, polarity and enable, and the three-edge path from a line to its flag can be timed exactly. Eight lines are enough to keep three flags pending at once. The bench then clears them one at a time and watches the request drop and rise again after each clear. It also lines up a held level-mode input against a clear in the same cycle to exercise the rule that detection takes priority.

// File: rtl/kbi_pkg.sv
// Shared definitions for the keyboard interrupt flag controller.
// Assumes a 2-bit register select on the write port.
package kbi_pkg;
    localparam int SEL_W = 2;

    typedef enum logic [SEL_W-1:0] {
        SEL_FLAG = 2'd0,
        SEL_EN   = 2'd1,
        SEL_POL  = 2'd2,
        SEL_MODE = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/kbi_sync.sv
// Multi-flop synchronizer for a bus of independent single-bit lines.
// Assumes each bit is unrelated to the others (no bus coherency needed)
// and that STAGES is at least 2. Flops reset to RST_VAL so that idle
// lines do not look like activity when reset is released.
module kbi_sync #(
    parameter int          W       = 8,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // First flop captures the raw lines.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[0] <= RST_VAL;
                    else        stage_q[0] <= async_i;
                end
            end else begin : g_next
                // Later flops shift the previous stage along.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[s] <= RST_VAL;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/kbi_regs.sv
// Configuration registers and write decode.
// Holds the enable, polarity and mode words and turns a flag-register
// write into a clear mask (bits written 0 are cleared).
// Assumes single-cycle write strobes; there is no read path here.
module kbi_regs
    import kbi_pkg::*;
#(
    parameter int W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic [W-1:0]     wr_data,
    output logic [W-1:0]     en_o,
    output logic [W-1:0]     pol_o,
    output logic [W-1:0]     mode_o,
    output logic [W-1:0]     clr_mask_o,
    output logic             flag_wr_o
);
    reg_sel_e     sel;
    logic         wr_en_reg;
    logic         wr_pol_reg;
    logic         wr_mode_reg;
    logic [W-1:0] en_q;
    logic [W-1:0] pol_q;
    logic [W-1:0] mode_q;

    // Decode the select into one strobe per register.
    always_comb begin
        sel         = reg_sel_e'(wr_sel);
        flag_wr_o   = wr_en && (sel == SEL_FLAG);
        wr_en_reg   = wr_en && (sel == SEL_EN);
        wr_pol_reg  = wr_en && (sel == SEL_POL);
        wr_mode_reg = wr_en && (sel == SEL_MODE);
        clr_mask_o  = flag_wr_o ? ~wr_data : '0;
    end

    // Enable register: all lines masked after reset.
    always_ff @(posedge clk) begin
        if (!rst_n)         en_q <= '0;
        else if (wr_en_reg) en_q <= wr_data;
    end

    // Polarity register: zero means active-low.
    always_ff @(posedge clk) begin
        if (!rst_n)          pol_q <= '0;
        else if (wr_pol_reg) pol_q <= wr_data;
    end

    // Mode register: zero means level detection.
    always_ff @(posedge clk) begin
        if (!rst_n)           mode_q <= '0;
        else if (wr_mode_reg) mode_q <= wr_data;
    end

    assign en_o   = en_q;
    assign pol_o  = pol_q;
    assign mode_o = mode_q;
endmodule

// File: rtl/kbi_detect.sv
// Per-line activity detector.
// Level mode: hit while the line equals its polarity bit.
// Edge mode: hit for one cycle when the line moves into the polarity
// level, judged from the current and previous synchronized samples.
// Assumes synchronized inputs that idle high out of reset.
module kbi_detect #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] sync_i,
    input  logic [W-1:0] pol_i,
    input  logic [W-1:0] mode_i,
    output logic [W-1:0] hit_o
);
    logic [W-1:0] prev_q;

    // Remember last cycle's synchronized value for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '1;
        else        prev_q <= sync_i;
    end

    generate
        for (genvar i = 0; i < W; i++) begin : g_line
            logic active_now;
            logic active_before;

            // Evaluate the active condition now and one cycle earlier.
            always_comb begin
                active_now    = (sync_i[i] == pol_i[i]);
                active_before = (prev_q[i] == pol_i[i]);
                hit_o[i]      = mode_i[i] ? (active_now && !active_before)
                                          : active_now;
            end

            // R4
            edge_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (mode_i[i] && $stable(sync_i[i]) && $stable(pol_i[i])) |-> !hit_o[i]);
        end
    endgenerate
endmodule

// File: rtl/kbi_flags.sv
// Sticky flag register and interrupt request.
// A hit sets its flag; a clear mask bit clears it unless a hit lands on
// the same bit in the same cycle. The request is registered and is held
// low for one cycle after each flag-register write, so every remaining
// enabled flag yields a new rising edge.
module kbi_flags #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] hit_i,
    input  logic [W-1:0] clr_mask_i,
    input  logic         flag_wr_i,
    input  logic [W-1:0] en_i,
    output logic [W-1:0] flag_o,
    output logic         irq_o
);
    logic [W-1:0] flag_q;
    logic [W-1:0] flag_d;
    logic         irq_q;
    logic         irq_d;

    // Next flag value: keep, clear by mask, then let hits win.
    always_comb begin
        flag_d = (flag_q & ~clr_mask_i) | hit_i;
        irq_d  = flag_wr_i ? 1'b0 : |(flag_q & en_i);
    end

    // Flag storage.
    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= flag_d;
    end

    // Registered interrupt request.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= irq_d;
    end

    assign flag_o = flag_q;
    assign irq_o  = irq_q;

    // R5
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((flag_q & ~clr_mask_i) != '0) |=>
        ((flag_q & $past(flag_q & ~clr_mask_i)) == $past(flag_q & ~clr_mask_i)));

    // R7
    hit_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_i != '0) |=> ((flag_q & $past(hit_i)) == $past(hit_i)));

    // R6
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((flag_q & clr_mask_i & ~hit_i) != '0) |=>
        ((flag_q & $past(clr_mask_i & ~hit_i)) == '0));

    // R9
    irq_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flag_wr_i |=> !irq_q);

    // R8
    irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_q) |-> $past((flag_q & en_i) != '0));
endmodule

// File: rtl/kbi_ctrl.sv
// Keyboard interrupt flag controller, top level.
// Synchronizes the key lines, detects level or edge activity per line,
// latches sticky flags that software clears bit by bit, and raises a
// masked interrupt request. Assumes key lines idle high during reset.
module kbi_ctrl
    import kbi_pkg::*;
#(
    parameter int N_LINES     = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] key_pin,
    input  logic               wr_en,
    input  logic [1:0]         wr_sel,
    input  logic [N_LINES-1:0] wr_data,
    output logic [N_LINES-1:0] key_flags,
    output logic               key_irq
);
    logic [N_LINES-1:0] sync_w;
    logic [N_LINES-1:0] en_w;
    logic [N_LINES-1:0] pol_w;
    logic [N_LINES-1:0] mode_w;
    logic [N_LINES-1:0] clr_w;
    logic [N_LINES-1:0] hit_w;
    logic               flag_wr_w;

    kbi_sync #(.W(N_LINES), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (key_pin),
        .sync_o  (sync_w)
    );

    kbi_regs #(.W(N_LINES)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_sel     (wr_sel),
        .wr_data    (wr_data),
        .en_o       (en_w),
        .pol_o      (pol_w),
        .mode_o     (mode_w),
        .clr_mask_o (clr_w),
        .flag_wr_o  (flag_wr_w)
    );

    kbi_detect #(.W(N_LINES)) u_detect (
        .clk    (clk),
        .rst_n  (rst_n),
        .sync_i (sync_w),
        .pol_i  (pol_w),
        .mode_i (mode_w),
        .hit_o  (hit_w)
    );

    kbi_flags #(.W(N_LINES)) u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .hit_i      (hit_w),
        .clr_mask_i (clr_w),
        .flag_wr_i  (flag_wr_w),
        .en_i       (en_w),
        .flag_o     (key_flags),
        .irq_o      (key_irq)
    );

    // R11
    cfg_write_keeps_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_sel != 2'd0) && (hit_w == '0)) |=> $stable(key_flags));
endmodule

// File: tb/sim_kbi_ctrl.sv
// Scoreboard bench: driver tasks push expected outputs, a monitor pops
// and compares them shortly after each falling edge.
module sim_kbi_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] key_pin = '1;
    logic         wr_en = 1'b0;
    logic [1:0]   wr_sel = 2'd0;
    logic [N-1:0] wr_data = '0;
    logic [N-1:0] key_flags;
    logic         key_irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    string        req_q[$];
    logic [N-1:0] flg_q[$];
    logic         irq_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    kbi_ctrl #(.N_LINES(N), .SYNC_STAGES(2)) u0 (
        .clk(clk), .rst_n(rst_n), .key_pin(key_pin), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_data(wr_data), .key_flags(key_flags), .key_irq(key_irq)
    );

    // Driver side: queue an expectation for the current falling edge.
    task automatic expect_out(input string req, input logic [N-1:0] f, input logic i);
        req_q.push_back(req);
        flg_q.push_back(f);
        irq_q.push_back(i);
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One register write; returns at the falling edge after it took effect.
    task automatic wr(input logic [1:0] sel, input logic [N-1:0] data);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Monitor: compare every queued expectation against the outputs.
    always @(negedge clk) begin
        #1;
        while (req_q.size() > 0) begin
            string        r;
            logic [N-1:0] ef;
            logic         ei;
            r  = req_q.pop_front();
            ef = flg_q.pop_front();
            ei = irq_q.pop_front();
            checks++;
            if (key_flags !== ef || key_irq !== ei) begin
                errors++;
                $display("FAIL %s: flags=%02h irq=%0b expected flags=%02h irq=%0b",
                         r, key_flags, key_irq, ef, ei);
            end
        end
    end

    initial begin
        wait_n(3);
        expect_out("R1 reset", 8'h00, 1'b0);
        wait_n(1);
        rst_n = 1'b1;
        // R1: default active-low level mode, enables off
        key_pin[0] = 1'b0;
        wait_n(5);
        expect_out("R1 defaults", 8'h01, 1'b0);
        wr(2'd1, 8'hFF);
        expect_out("R8 irq lags enable", 8'h01, 1'b0);
        wait_n(1);
        expect_out("R8 irq follows enable", 8'h01, 1'b1);
        // R5 sticky after release
        key_pin[0] = 1'b1;
        wait_n(5);
        expect_out("R5 sticky", 8'h01, 1'b1);
        // R6 clear by zero
        wr(2'd0, 8'hFE);
        expect_out("R6 clear", 8'h00, 1'b0);
        wait_n(3);
        expect_out("R6 stays clear", 8'h00, 1'b0);
        // R3 and R7: held level re-sets against a clear
        key_pin[1] = 1'b0;
        wait_n(5);
        expect_out("R3 level set", 8'h02, 1'b1);
        wr(2'd0, 8'hFD);
        expect_out("R7 hit wins", 8'h02, 1'b0);
        wait_n(1);
        expect_out("R9 reassert", 8'h02, 1'b1);
        key_pin[1] = 1'b1;
        wait_n(3);
        wr(2'd0, 8'hFD);
        wait_n(2);
        expect_out("R3 released clear", 8'h00, 1'b0);
        // R4 edge mode, held level no re-set
        wr(2'd3, 8'hFF);
        key_pin[2] = 1'b0;
        wait_n(5);
        expect_out("R4 edge set", 8'h04, 1'b1);
        wr(2'd0, 8'hFB);
        wait_n(4);
        expect_out("R4 held no reset", 8'h00, 1'b0);
        // R4 active-high edge on line 3; R11 polarity write keeps flags
        wr(2'd2, 8'h08);
        wait_n(4);
        expect_out("R11 cfg write", 8'h00, 1'b0);
        key_pin[3] = 1'b0;
        wait_n(5);
        expect_out("R4 move away", 8'h00, 1'b0);
        key_pin[3] = 1'b1;
        wait_n(5);
        expect_out("R4 active-high edge", 8'h08, 1'b1);
        wr(2'd0, 8'hF7);
        wait_n(2);
        // R9 several flags cleared one at a time
        key_pin[4] = 1'b0; key_pin[5] = 1'b0; key_pin[6] = 1'b0;
        wait_n(5);
        expect_out("R9 three set", 8'h70, 1'b1);
        wr(2'd0, 8'hEF);
        expect_out("R9 gap 1", 8'h60, 1'b0);
        wait_n(1);
        expect_out("R9 refire 1", 8'h60, 1'b1);
        wr(2'd0, 8'hDF);
        expect_out("R9 gap 2", 8'h40, 1'b0);
        wait_n(1);
        expect_out("R9 refire 2", 8'h40, 1'b1);
        wr(2'd0, 8'hBF);
        expect_out("R9 last clear", 8'h00, 1'b0);
        wait_n(1);
        expect_out("R9 no refire", 8'h00, 1'b0);
        // R10 masked line, R2 latency
        wr(2'd1, 8'h7F);
        key_pin[7] = 1'b0;
        wait_n(2);
        expect_out("R2 not yet", 8'h00, 1'b0);
        wait_n(1);
        expect_out("R2 third edge", 8'h80, 1'b0);
        wait_n(2);
        expect_out("R10 masked", 8'h80, 1'b0);
        wr(2'd1, 8'hFF);
        expect_out("R8 one cycle lag", 8'h80, 1'b0);
        wait_n(1);
        expect_out("R8 unmasked", 8'h80, 1'b1);
        // R6 ones leave bits untouched
        wr(2'd0, 8'hFF);
        expect_out("R6 ones keep", 8'h80, 1'b0);
        wait_n(1);
        expect_out("R9 after ones", 8'h80, 1'b1);
        wait_n(2);
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule